// File: doc/BRIEF.md
# Serial Configuration Frame Receiver

This block takes a configuration stream that arrives one bit per clock and turns it into column write operations for a configuration memory that sits outside the block. It first searches the stream for a header. The header is a run of one bits followed by a fixed four-bit preamble. After the header come a 24-bit length count and, when the build includes one, a 32-bit identification word. After that the block decodes a sequence of framed records. Each record yields a column address and a column data word. The block issues a one-cycle write strobe once the record's stop bits have been confirmed.

A compressed record carries no payload. It writes the most recently accepted data word again, at a new column address. A record whose program bit is clear marks the end of configuration. The identification word can switch on a parity check for every later record. Parity errors and framing errors raise flags that stay set until reset. The done flag rises only when two conditions hold: the end record has been seen, and the number of clocks received since the length field has reached the length count.

The controller moves through these states in order: `ST_HUNT` (header search), `ST_LEN` (length capture), `ST_ID` (identification word), `ST_GAP` (idle ones between records), `ST_CTRL` (control nibble), `ST_ADDR`, `ST_ALIGN`, `ST_WCTL`, `ST_DATA`, `ST_STOP` and `ST_END`. The transitions are as follows:
- `ST_HUNT` moves to `ST_LEN` when the preamble matches.
- `ST_LEN` moves to `ST_ID`, or to `ST_GAP` when there is no identification word.
- `ST_ID` moves to `ST_GAP`.
- `ST_GAP` moves to `ST_CTRL` on a zero (the start bit).
- `ST_CTRL` moves to `ST_ADDR` when the program bit is set, and to `ST_END` when it is clear.
- `ST_ADDR` moves to `ST_ALIGN`, or to `ST_WCTL` when the alignment width is zero.
- `ST_ALIGN` moves to `ST_WCTL`.
- `ST_WCTL` moves to `ST_DATA`, or to `ST_STOP` for a compressed record.
- `ST_DATA` moves to `ST_STOP`.
- `ST_STOP` moves to `ST_GAP` after the required stop bits. It moves to `ST_CTRL` if a zero arrives early.
- `ST_END` is terminal.

Top module: `cfg_frame_rx`

## Requirements
- R1: The stream is ignored, and nothing is written, until the five-bit pattern 1,0,0,1,0 is seen. This is the last one bit of the header run followed by the preamble 0010. The next 24 bits, most significant first, form the length count.
- R2: When ID_EN is nonzero, a 32-bit identification word follows the length count, most significant bit first. Its last received bit (bit 0) enables parity checking for all later records when it is 1.
- R3: A record is made of the following fields, in this order:
  - a 0 start bit;
  - the control bits program, compress, odd-parity and even-parity;
  - an 11-bit column address, most significant bit first;
  - ALIGN_W alignment bits and one write-control bit, whose values are ignored;
  - for an uncompressed record, DATA_W data bits, with the first received bit becoming data bit DATA_W-1.
- R4: After an accepted record's MIN_STOP stop bits, `col_we` is high for exactly one cycle, beginning the clock after the last required stop bit. During that cycle `col_addr` and `col_data` carry the record's address and word.
- R5: A compressed record (compress bit 1) writes, at its own address, the data word of the last uncompressed record that was written.
- R6: A compressed record that arrives before any uncompressed record has been written sets `frm_err` and produces no write.
- R7: If a 0 arrives before MIN_STOP stop bits have been received, `frm_err` is set and the record is not written. That 0 is taken as the start bit of the next record.
- R8: Any number of extra one bits between records is treated as idle and has no effect.
- R9: While parity is enabled, a record is rejected if either parity bit is wrong. The odd-parity bit must equal the XNOR reduction of {address, data word}. The even-parity bit must equal the XOR reduction of the same bits. A rejected record sets `par_err` and is not written. While parity is disabled, the parity bits are ignored.
- R10: A record with program bit 0 ends loading, and no later record is written. The block counts clocks from the first bit after the length field. `cfg_done` rises one clock after both of these hold: the end record has been decoded, and the count has reached the length value. `cfg_done` then stays high.
- R11: Reset clears all outputs. `par_err`, `frm_err` and `cfg_done` are sticky until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one stream bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bit | input | 1 | Serial configuration bit |
| col_addr | output | 11 | Column address of the current write |
| col_data | output | DATA_W | Column data of the current write |
| col_we | output | 1 | One-cycle column write strobe |
| cfg_done | output | 1 | Loading complete |
| par_err | output | 1 | Sticky parity error |
| frm_err | output | 1 | Sticky framing error |

## Verification
The bench builds the block with DATA_W=16, ALIGN_W=2, MIN_STOP=3 and ID_EN=1. With these values one record is about 40 bits long, so a few hundred clocks cover many records. Two separate loads are run. The first keeps parity off and uses a short length count, so the count is already reached before the end record arrives. The second turns parity on and uses a long count, so `cfg_done` waits on the clock count after the end record, and the bench can check the exact cycle in which it rises.

// File: rtl/cfg_rx_pkg.sv
`timescale 1ns/1ps
package cfg_rx_pkg;

    typedef enum logic [3:0] {
        ST_HUNT,
        ST_LEN,
        ST_ID,
        ST_GAP,
        ST_CTRL,
        ST_ADDR,
        ST_ALIGN,
        ST_WCTL,
        ST_DATA,
        ST_STOP,
        ST_END
    } rx_state_e;

    localparam int ADDR_W = 11;
    localparam int LEN_W  = 24;
    localparam int ID_W   = 32;
    localparam int CTRL_W = 4;

    // last header bit of the one run followed by the preamble
    localparam logic [4:0] SYNC_PAT = 5'b10010;

endpackage

// File: rtl/cfg_rx_parity.sv
`timescale 1ns/1ps
module cfg_rx_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] bits,
    input  logic         odd_bit,
    input  logic         even_bit,
    output logic         bad
);
    logic x_red;

    assign x_red = ^bits;
    // odd bit makes total ones odd, even bit makes them even
    assign bad   = (even_bit != x_red) || (odd_bit != ~x_red);
endmodule

// File: rtl/cfg_rx_clkcnt.sv
`timescale 1ns/1ps
module cfg_rx_clkcnt #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (en && (cnt != '1))
            cnt <= cnt + W'(1);
    end

    // R10: count advances by one on every enabled clock until saturation
    assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (cnt != '1)) |=> (cnt == $past(cnt) + W'(1)));
endmodule

// File: rtl/cfg_rx_fsm.sv
`timescale 1ns/1ps
module cfg_rx_fsm
    import cfg_rx_pkg::*;
#(
    parameter int DATA_W   = 110,
    parameter int ALIGN_W  = 2,
    parameter int MIN_STOP = 3,
    parameter int ID_EN    = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_in,
    input  logic [3:0] sync_win,
    // holds program bit on the last control bit, compress bit afterwards
    input  logic      route_bit,
    output rx_state_e state_q,
    output rx_state_e state_d
);
    localparam int M1     = (DATA_W > ID_W) ? DATA_W : ID_W;
    localparam int M2     = (M1 > MIN_STOP) ? M1 : MIN_STOP;
    localparam int FMAX   = (M2 > ALIGN_W) ? M2 : ALIGN_W;
    localparam int FCNT_W = $clog2(FMAX + 1);

    localparam logic [FCNT_W-1:0] LEN_LAST   = FCNT_W'(LEN_W - 1);
    localparam logic [FCNT_W-1:0] ID_LAST    = FCNT_W'(ID_W - 1);
    localparam logic [FCNT_W-1:0] CTRL_LAST  = FCNT_W'(CTRL_W - 1);
    localparam logic [FCNT_W-1:0] ADDR_LAST  = FCNT_W'(ADDR_W - 1);
    localparam logic [FCNT_W-1:0] ALIGN_LAST = FCNT_W'((ALIGN_W > 0) ? ALIGN_W - 1 : 0);
    localparam logic [FCNT_W-1:0] DATA_LAST  = FCNT_W'(DATA_W - 1);
    localparam logic [FCNT_W-1:0] STOP_LAST  = FCNT_W'(MIN_STOP - 1);

    logic [FCNT_W-1:0] fcnt_q;

    // state register and per-field bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            fcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                fcnt_q <= '0;
            else
                fcnt_q <= fcnt_q + FCNT_W'(1);
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:  if ({sync_win, bit_in} == SYNC_PAT) state_d = ST_LEN;
            ST_LEN:   if (fcnt_q == LEN_LAST) state_d = (ID_EN != 0) ? ST_ID : ST_GAP;
            ST_ID:    if (fcnt_q == ID_LAST) state_d = ST_GAP;
            ST_GAP:   if (!bit_in) state_d = ST_CTRL;
            ST_CTRL:  if (fcnt_q == CTRL_LAST) state_d = route_bit ? ST_ADDR : ST_END;
            ST_ADDR:  if (fcnt_q == ADDR_LAST) state_d = (ALIGN_W > 0) ? ST_ALIGN : ST_WCTL;
            ST_ALIGN: if (fcnt_q == ALIGN_LAST) state_d = ST_WCTL;
            ST_WCTL:  state_d = route_bit ? ST_STOP : ST_DATA;
            ST_DATA:  if (fcnt_q == DATA_LAST) state_d = ST_STOP;
            ST_STOP: begin
                if (!bit_in)
                    state_d = ST_CTRL;
                else if (fcnt_q == STOP_LAST)
                    state_d = ST_GAP;
            end
            ST_END:   state_d = ST_END;
            default:  state_d = ST_HUNT;
        endcase
    end

    // R7: a zero inside the stop run is taken as the next start bit
    assert_short_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !bit_in) |=> (state_q == ST_CTRL));

    // R10: the end state is never left
    assert_end_terminal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_END) |=> (state_q == ST_END));
endmodule

// File: rtl/cfg_frame_rx.sv
`timescale 1ns/1ps
module cfg_frame_rx
    import cfg_rx_pkg::*;
#(
    parameter int DATA_W   = 110,
    parameter int ALIGN_W  = 2,
    parameter int MIN_STOP = 3,
    parameter int ID_EN    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bit,
    output logic [10:0]       col_addr,
    output logic [DATA_W-1:0] col_data,
    output logic              col_we,
    output logic              cfg_done,
    output logic              par_err,
    output logic              frm_err
);
    localparam int PAR_W = ADDR_W + DATA_W;

    rx_state_e          state_q, state_d;
    logic [3:0]         win_q;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   clk_cnt;
    logic               par_en_q;
    logic [2:0]         ctl_q;       // {comp, opar, epar} once the nibble is in
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  data_q;
    logic [DATA_W-1:0]  held_q;
    logic               have_data_q;
    logic [DATA_W-1:0]  word;
    logic               par_bad;
    logic               commit;
    logic               cnt_en;

    cfg_rx_fsm #(
        .DATA_W   (DATA_W),
        .ALIGN_W  (ALIGN_W),
        .MIN_STOP (MIN_STOP),
        .ID_EN    (ID_EN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (cfg_bit),
        .sync_win  (win_q),
        .route_bit (ctl_q[2]),
        .state_q   (state_q),
        .state_d   (state_d)
    );

    assign cnt_en = (state_q != ST_HUNT) && (state_q != ST_LEN);

    cfg_rx_clkcnt #(
        .W (LEN_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cnt_en),
        .cnt   (clk_cnt)
    );

    assign word   = ctl_q[2] ? held_q : data_q;
    assign commit = (state_q == ST_STOP) && (state_d == ST_GAP);

    cfg_rx_parity #(
        .W (PAR_W)
    ) u_par (
        .bits     ({addr_q, word}),
        .odd_bit  (ctl_q[1]),
        .even_bit (ctl_q[0]),
        .bad      (par_bad)
    );

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q       <= '0;
            len_q       <= '0;
            par_en_q    <= 1'b0;
            ctl_q       <= '0;
            addr_q      <= '0;
            data_q      <= '0;
            held_q      <= '0;
            have_data_q <= 1'b0;
            col_addr    <= '0;
            col_data    <= '0;
            col_we      <= 1'b0;
            cfg_done    <= 1'b0;
            par_err     <= 1'b0;
            frm_err     <= 1'b0;
        end else begin
            col_we <= 1'b0;
            if (state_q == ST_END && clk_cnt >= len_q)
                cfg_done <= 1'b1;
            case (state_q)
                ST_HUNT: win_q <= {win_q[2:0], cfg_bit};
                ST_LEN:  len_q <= {len_q[LEN_W-2:0], cfg_bit};
                ST_ID:   if (state_d != ST_ID) par_en_q <= cfg_bit;
                ST_CTRL: ctl_q <= {ctl_q[1:0], cfg_bit};
                ST_ADDR: addr_q <= {addr_q[ADDR_W-2:0], cfg_bit};
                ST_DATA: data_q <= {data_q[DATA_W-2:0], cfg_bit};
                ST_STOP: begin
                    if (!cfg_bit) begin
                        frm_err <= 1'b1;
                    end else if (commit) begin
                        if (ctl_q[2] && !have_data_q) begin
                            frm_err <= 1'b1;
                        end else if (par_en_q && par_bad) begin
                            par_err <= 1'b1;
                        end else begin
                            col_we   <= 1'b1;
                            col_addr <= addr_q;
                            col_data <= word;
                            if (!ctl_q[2]) begin
                                held_q      <= data_q;
                                have_data_q <= 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R4: strobe lasts one cycle
    assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        col_we |=> !col_we);

    // R4: a write only follows a stop-bit run
    assert_we_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        col_we |-> ($past(state_q) == ST_STOP));

    // R9: no write goes out with a parity mismatch while checking is on
    assert_par_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (col_we && par_en_q) |-> !$past(par_bad));

    // R10: no write after the end record
    assert_no_we_in_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_END) |-> !col_we);

    // R10: done implies the clock count reached the length
    assert_done_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> (clk_cnt >= len_q));

    // R11: sticky flags
    assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_done) |-> cfg_done);
    assert_perr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(par_err) |-> par_err);
    assert_ferr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frm_err) |-> frm_err);
endmodule

// File: tb/cfg_frame_rx_bench.sv
`timescale 1ns/1ps
module cfg_frame_rx_bench;
    localparam int DW = 16;
    localparam int AW = 2;
    localparam int NS = 3;

    typedef struct packed {
        logic [10:0]   a;
        logic [DW-1:0] d;
    } wr_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_bit = 1'b1;
    logic [10:0]   col_addr;
    logic [DW-1:0] col_data;
    logic          col_we;
    logic          cfg_done;
    logic          par_err;
    logic          frm_err;

    int  checks = 0;
    int  bad = 0;
    int  post_len = 0;
    bit  count_on = 1'b0;
    bit  cnt_flag = 1'b0;
    wr_t exp_q[$];

    always #2 clk = ~clk;

    cfg_frame_rx #(
        .DATA_W   (DW),
        .ALIGN_W  (AW),
        .MIN_STOP (NS),
        .ID_EN    (1)
    ) u_cfg_frame_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_bit  (cfg_bit),
        .col_addr (col_addr),
        .col_data (col_data),
        .col_we   (col_we),
        .cfg_done (cfg_done),
        .par_err  (par_err),
        .frm_err  (frm_err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bench clock counter mirrors the requirement's count of post-length clocks
    always @(posedge clk) begin
        if (!rst_n)
            post_len <= 0;
        else if (cnt_flag)
            post_len <= post_len + 1;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && col_we) begin
            wr_t w;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4/R10 unexpected write", {col_addr, col_data}, 0);
            end else begin
                w = exp_q.pop_front();
                chk({col_addr, col_data} == w, "R4 write contents", {col_addr, col_data}, w);
            end
        end
    end

    task automatic send_bit(input logic b);
        @(negedge clk);
        cfg_bit  = b;
        cnt_flag = count_on;
    endtask

    task automatic send_field(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        count_on = 1'b0;
        cnt_flag = 1'b0;
        cfg_bit = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_header(input logic [23:0] len, input logic pen);
        send_field(64'h7, 3);
        send_field(64'h2, 4);
        send_field(len, 24);
        count_on = 1'b1;
        send_field({63'h0, pen}, 32);
    endtask

    task automatic send_frame(input logic comp, input logic [10:0] a, input logic [DW-1:0] d,
                              input logic [DW-1:0] held, input int nstop,
                              input bit bad_par, input bit expect_wr);
        logic [DW-1:0] w;
        logic x;
        w = comp ? held : d;
        x = ^{a, w};
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(comp);
        send_bit(~x);
        send_bit(bad_par ? ~x : x);
        send_field(a, 11);
        send_field(64'h2, AW);
        send_bit(1'b1);
        if (!comp) send_field(d, DW);
        if (expect_wr) exp_q.push_back({a, w});
        for (int i = 0; i < nstop; i++) send_bit(1'b1);
    endtask

    task automatic send_end();
        send_field(64'h0, 5);
        send_bit(1'b1);
    endtask

    initial begin
        #(4 * 200000);
        chk(1'b0, "R10 watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        // ---- load A: parity off, short length count ----
        do_reset();
        @(negedge clk);
        chk({col_we, cfg_done, par_err, frm_err} == 4'b0, "R11 reset state",
            {col_we, cfg_done, par_err, frm_err}, 0);
        send_field(64'h0D6, 10);                 // R1: noise before header
        send_header(24'd30, 1'b0);
        send_frame(1'b1, 11'h005, '0, '0, NS, 1'b0, 1'b0);   // R6
        send_bit(1'b1);
        chk(frm_err == 1'b1, "R6 compressed before data", frm_err, 1);
        chk(par_err == 1'b0, "R6 no parity flag", par_err, 0);
        send_frame(1'b0, 11'h123, 16'hBEEF, '0, NS, 1'b1, 1'b1); // R9 off, R3
        send_bit(1'b1);
        chk(par_err == 1'b0, "R9 parity ignored when off", par_err, 0);
        chk(cfg_done == 1'b0, "R10 count reached without end", cfg_done, 0);
        send_end();
        send_bit(1'b1);
        chk(cfg_done == 1'b1, "R10 done after end", cfg_done, 1);
        send_frame(1'b0, 11'h321, 16'h1111, '0, NS, 1'b0, 1'b0); // R10 ignored
        send_bit(1'b1);
        chk(exp_q.size() == 0, "R1/R4 pending writes load A", exp_q.size(), 0);
        chk(cfg_done == 1'b1, "R11 done sticky", cfg_done, 1);

        // ---- load B: parity on, long length count ----
        do_reset();
        @(negedge clk);
        chk({col_we, cfg_done, par_err, frm_err} == 4'b0, "R11 reset clears flags",
            {col_we, cfg_done, par_err, frm_err}, 0);
        send_header(24'd600, 1'b1);              // R2
        send_frame(1'b0, 11'h00A, 16'h1234, '0, NS, 1'b0, 1'b1);
        for (int i = 0; i < 7; i++) send_bit(1'b1);           // R8
        send_frame(1'b1, 11'h7FF, '0, 16'h1234, NS, 1'b0, 1'b1); // R5
        send_frame(1'b0, 11'h001, 16'hAAAA, '0, NS, 1'b1, 1'b0); // R9
        send_bit(1'b1);
        chk(par_err == 1'b1, "R9 parity mismatch flagged", par_err, 1);
        chk(frm_err == 1'b0, "R8 idle ones no framing error", frm_err, 0);
        send_frame(1'b0, 11'h002, 16'h5555, '0, 2, 1'b0, 1'b0);  // R7 short stop
        send_frame(1'b0, 11'h003, 16'h0F0F, '0, NS, 1'b0, 1'b1);
        send_bit(1'b1);
        chk(frm_err == 1'b1, "R7 short stop flagged", frm_err, 1);
        send_frame(1'b1, 11'h004, '0, 16'h0F0F, NS, 1'b0, 1'b1); // R5 held word
        send_end();
        chk(cfg_done == 1'b0, "R10 end seen, count short", cfg_done, 0);
        while (post_len <= 602) begin
            send_bit(1'b1);
            if (post_len >= 598)
                chk(cfg_done == (post_len > 600), "R10 done timing", cfg_done, post_len > 600);
        end
        chk(exp_q.size() == 0, "R4/R5 pending writes load B", exp_q.size(), 0);
        chk(par_err == 1'b1, "R11 parity flag sticky", par_err, 1);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule